// File: doc/BRIEF.md
# Configuration Bitstream Header Parser

This block walks the header of a configuration file that arrives one byte per handshake on a valid/ready stream. Each byte comes with its position in the file, and the total file length is held on a separate input for the whole parse. After a start pulse the block searches for the first 0xFF sync byte and checks the marker nibble of the byte after it. It then assembles the payload bit count from four bytes whose fields straddle nibble boundaries. Finally it compares the claimed payload size with the file length.

When the outcome is known the block raises a single-cycle `done` pulse. Alongside it sit a two-bit status, the offset at which the serial loader should begin, the assembled bit count and the lengths of the leading text fields of the header. These results are held until the next start. While idle the block does not accept bytes, so a caller can leave the stream driven without disturbing the results.

Top module: `bitstream_hdr_parser`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle within one clock, even during a parse: `in_ready` and `done` go low and `status`, `bit_count`, `payload_off` and `field_len` all read 0.
- R2: `start` is acted on only while idle, and it clears all results. While idle, `in_ready` stays low and bytes offered with `in_valid` high are ignored: `status`, `bit_count` and `payload_off` keep their values.
- R3: The sync byte is the first byte with value 0xFF in file order. `payload_off` reports its index plus one.
- R4: When no 0xFF appears among the `file_len` bytes, the status is 1 (no sync). A start with `file_len` equal to 0 also ends with status 1.
- R5: The byte after the sync must have upper nibble 0x2. Any other value ends the parse with status 2 (corrupt header).
- R6: The bit count is 24 bits wide and is built from the four bytes starting at `payload_off`: bits 23:20 from the low nibble of the first, bits 19:12 from the second, bits 11:4 from the third, and bits 3:0 from the upper nibble of the fourth.
- R7: When `payload_off` plus the bit count divided by 8 (rounded down) exceeds `file_len`, the status is 3 (file too short). When the sum equals `file_len` or is less, the status is 0 (ok).
- R8: When the file ends before the fourth count byte has been taken, the status is 3. This includes the case where the sync is the last byte.
- R9: The first field length is the byte at index 15, and that field's text starts at index 16. Each later length byte sits two bytes past the end of the previous text, and its text starts one byte after the length. Three lengths are reported on `field_len`, field k in bits 8k+7:8k. A length whose index is not reached before the parse ends reads 0.
- R10: `done` is a one-cycle pulse and `in_ready` is low while it is high. For an error outcome, `done` is visible in the cycle after the deciding byte's handshake. For status 0, it comes one cycle later, after `bit_count` has already settled.
- R11: Results do not depend on gaps in `in_valid`. Only bytes accepted with `in_valid` and `in_ready` both high count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a parse (idle only) |
| file_len | input | IDX_W | Total file length in bytes, held during the parse |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte accepted when both are high |
| in_data | input | 8 | File byte |
| in_index | input | IDX_W | Index of the byte in the file |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 no sync, 2 corrupt header, 3 too short |
| bit_count | output | 24 | Assembled payload bit count |
| payload_off | output | IDX_W | Index of the byte after the sync |
| field_len | output | NUM_FIELDS*8 | Captured text field lengths |

## Verification
The bench builds the block with a 16-bit index and three fields. This keeps file lengths small enough that the size comparison can be driven to its exact boundary from both sides, while count values well past any legal length still reach the too-short path. It sweeps the sync position, all sixteen marker nibbles, truncation at each count byte and a grid of field lengths. An arithmetic model in the bench predicts every result and the completion latency, and some runs are repeated with stalls on the input.

// File: rtl/bshp_pkg.sv
package bshp_pkg;

    localparam int CNT_W = 24;
    localparam logic [7:0] SYNC_BYTE = 8'hFF;
    localparam logic [3:0] MARK_NIB = 4'h2;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_NOSYNC  = 2'd1,
        ST_CORRUPT = 2'd2,
        ST_SHORT   = 2'd3
    } hdr_status_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_HUNT  = 3'd1,
        PH_MARK  = 3'd2,
        PH_CNT   = 3'd3,
        PH_CHECK = 3'd4
    } phase_e;

    typedef struct packed {
        logic [1:0] slot;
        logic [7:0] data;
    } cnt_byte_t;

    // Place one header byte into the running bit count.
    function automatic logic [CNT_W-1:0] merge_count(
        input logic [CNT_W-1:0] cur,
        input cnt_byte_t        cb
    );
        logic [CNT_W-1:0] r;
        r = cur;
        case (cb.slot)
            2'd0:    r[23:20] = cb.data[3:0];
            2'd1:    r[19:12] = cb.data;
            2'd2:    r[11:4]  = cb.data;
            default: r[3:0]   = cb.data[7:4];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bshp_count_asm.sv
module bshp_count_asm
    import bshp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  cnt_byte_t        cb,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= merge_count(count_q, cb);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/bshp_field_track.sv
module bshp_field_track #(
    parameter int IDX_W      = 24,
    parameter int NUM_FIELDS = 3,
    parameter int FIRST_POS  = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              data,
    output logic [NUM_FIELDS*8-1:0] lens
);

    localparam int PW = IDX_W + 2;
    localparam int KW = $clog2(NUM_FIELDS + 1);

    logic [PW-1:0] pos_q;
    logic [KW-1:0] k_q;
    logic [7:0]    len_q [NUM_FIELDS];
    logic          hit;

    assign hit = en && (k_q < KW'(NUM_FIELDS)) && (pos_q == {2'b00, idx});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos_q <= PW'(FIRST_POS);
            k_q   <= '0;
            for (int f = 0; f < NUM_FIELDS; f++) begin
                len_q[f] <= '0;
            end
        end else if (hit) begin
            len_q[k_q] <= data;
            pos_q      <= pos_q + PW'(data) + PW'(3);
            k_q        <= k_q + KW'(1);
        end
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_pack
        assign lens[g*8 +: 8] = len_q[g];
    end

endmodule

// File: rtl/bshp_len_check.sv
module bshp_len_check
    import bshp_pkg::*;
#(
    parameter int IDX_W = 24
) (
    input  logic [IDX_W-1:0] off,
    input  logic [CNT_W-1:0] count,
    input  logic [IDX_W-1:0] file_len,
    output logic             too_short
);

    localparam int BW = CNT_W - 3;
    localparam int SW = ((IDX_W > BW) ? IDX_W : BW) + 1;

    logic [SW-1:0] need;

    always_comb begin
        need      = SW'(off) + SW'(count[CNT_W-1:3]);
        too_short = need > SW'(file_len);
    end

endmodule

// File: rtl/bitstream_hdr_parser.sv
module bitstream_hdr_parser
    import bshp_pkg::*;
#(
    parameter int IDX_W      = 24,
    parameter int NUM_FIELDS = 3,
    parameter int FIRST_POS  = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [IDX_W-1:0]        file_len,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [7:0]              in_data,
    input  logic [IDX_W-1:0]        in_index,
    output logic                    done,
    output logic [1:0]              status,
    output logic [CNT_W-1:0]        bit_count,
    output logic [IDX_W-1:0]        payload_off,
    output logic [NUM_FIELDS*8-1:0] field_len
);

    phase_e           state_q;
    hdr_status_e      status_q;
    logic             done_q;
    logic [1:0]       slot_q;
    logic [IDX_W-1:0] off_q;

    logic             hs;
    logic             last;
    logic             clr;
    logic             mark_ok;
    logic             too_short;
    logic             cnt_load;
    cnt_byte_t        cb;

    assign in_ready = (state_q == PH_HUNT) || (state_q == PH_MARK) || (state_q == PH_CNT);
    assign hs       = in_valid && in_ready;
    assign last     = (in_index == file_len - IDX_W'(1));
    assign clr      = start && (state_q == PH_IDLE);
    assign mark_ok  = (in_data[7:4] == MARK_NIB);
    assign cnt_load = hs && (((state_q == PH_MARK) && mark_ok) || (state_q == PH_CNT));

    always_comb begin
        cb.data = in_data;
        cb.slot = (state_q == PH_MARK) ? 2'd0 : slot_q;
    end

    bshp_count_asm u_count (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .load  (cnt_load),
        .cb    (cb),
        .count (bit_count)
    );

    bshp_field_track #(
        .IDX_W      (IDX_W),
        .NUM_FIELDS (NUM_FIELDS),
        .FIRST_POS  (FIRST_POS)
    ) u_fields (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .en   (hs),
        .idx  (in_index),
        .data (in_data),
        .lens (field_len)
    );

    bshp_len_check #(
        .IDX_W (IDX_W)
    ) u_len (
        .off       (off_q),
        .count     (bit_count),
        .file_len  (file_len),
        .too_short (too_short)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PH_IDLE;
            status_q <= ST_OK;
            done_q   <= 1'b0;
            slot_q   <= 2'd0;
            off_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                PH_IDLE: begin
                    if (start) begin
                        status_q <= ST_OK;
                        off_q    <= '0;
                        slot_q   <= 2'd0;
                        if (file_len == '0) begin
                            status_q <= ST_NOSYNC;
                            done_q   <= 1'b1;
                        end else begin
                            state_q <= PH_HUNT;
                        end
                    end
                end
                PH_HUNT: begin
                    if (hs) begin
                        if (in_data == SYNC_BYTE) begin
                            off_q <= in_index + IDX_W'(1);
                            if (last) begin
                                status_q <= ST_SHORT;
                                done_q   <= 1'b1;
                                state_q  <= PH_IDLE;
                            end else begin
                                state_q <= PH_MARK;
                            end
                        end else if (last) begin
                            status_q <= ST_NOSYNC;
                            done_q   <= 1'b1;
                            state_q  <= PH_IDLE;
                        end
                    end
                end
                PH_MARK: begin
                    if (hs) begin
                        if (!mark_ok) begin
                            status_q <= ST_CORRUPT;
                            done_q   <= 1'b1;
                            state_q  <= PH_IDLE;
                        end else if (last) begin
                            status_q <= ST_SHORT;
                            done_q   <= 1'b1;
                            state_q  <= PH_IDLE;
                        end else begin
                            slot_q  <= 2'd1;
                            state_q <= PH_CNT;
                        end
                    end
                end
                PH_CNT: begin
                    if (hs) begin
                        if (slot_q == 2'd3) begin
                            state_q <= PH_CHECK;
                        end else if (last) begin
                            status_q <= ST_SHORT;
                            done_q   <= 1'b1;
                            state_q  <= PH_IDLE;
                        end else begin
                            slot_q <= slot_q + 2'd1;
                        end
                    end
                end
                PH_CHECK: begin
                    status_q <= too_short ? ST_SHORT : ST_OK;
                    done_q   <= 1'b1;
                    state_q  <= PH_IDLE;
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    assign done        = done_q;
    assign status      = status_q;
    assign payload_off = off_q;

endmodule

// File: rtl/bshp_checker.sv
module bshp_checker
    import bshp_pkg::*;
#(
    parameter int IDX_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [IDX_W-1:0] file_len,
    input logic             in_ready,
    input logic             done,
    input logic [1:0]       status,
    input logic [CNT_W-1:0] bit_count,
    input logic [IDX_W-1:0] payload_off,
    input phase_e           state_q
);

    // R1
    rst_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!in_ready && !done && status == 2'd0 && bit_count == '0 && payload_off == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_IDLE && !start) |=> ($stable(status) && $stable(bit_count) && $stable(payload_off)));

    // R10
    done_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    // R10
    ok_count_settled_chk: assert property (@(posedge clk) disable iff (rst)
        (done && status == 2'd0) |-> $stable(bit_count));

    // R7
    ok_fits_chk: assert property (@(posedge clk) disable iff (rst)
        (done && status == 2'd0) |->
            ({8'd0, payload_off} + {{(IDX_W+8-(CNT_W-3)){1'b0}}, bit_count[CNT_W-1:3]} <= {8'd0, file_len}));

endmodule

bind bitstream_hdr_parser bshp_checker #(.IDX_W(IDX_W)) u_bshp_checker (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .file_len    (file_len),
    .in_ready    (in_ready),
    .done        (done),
    .status      (status),
    .bit_count   (bit_count),
    .payload_off (payload_off),
    .state_q     (state_q)
);

// File: tb/test_bitstream_hdr_parser.sv
module test_bitstream_hdr_parser;
    import bshp_pkg::*;

    localparam int IDX_W = 16;
    localparam int NF    = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [IDX_W-1:0]    file_len = '0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [7:0]          in_data = '0;
    logic [IDX_W-1:0]    in_index = '0;
    logic                done;
    logic [1:0]          status;
    logic [CNT_W-1:0]    bit_count;
    logic [IDX_W-1:0]    payload_off;
    logic [NF*8-1:0]     field_len;

    bitstream_hdr_parser #(.IDX_W(IDX_W), .NUM_FIELDS(NF), .FIRST_POS(15)) i_bitstream_hdr_parser (
        .clk(clk), .rst(rst), .start(start), .file_len(file_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_index(in_index),
        .done(done), .status(status), .bit_count(bit_count),
        .payload_off(payload_off), .field_len(field_len)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int gap_mod = 0;
    bit finished = 0;
    logic [7:0] mem [64];

    int e_st, e_off, e_cnt, e_lat;
    int e_len [NF];

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill();
        for (int i = 0; i < 64; i++) mem[i] = 8'((i * 13) % 255);
    endtask

    task automatic put_count(input int p, input int cnt, input int mark);
        mem[p]     = 8'h20 | 8'((cnt >> 20) & 15);
        mem[p]     = {4'(mark), mem[p][3:0]};
        mem[p + 1] = 8'((cnt >> 12) & 255);
        mem[p + 2] = 8'((cnt >> 4) & 255);
        mem[p + 3] = {4'(cnt & 15), 4'hA};
    endtask

    task automatic model(input int flen);
        int pos, k, ph;
        logic [7:0] b;
        pos = 15; k = 0; ph = 0;
        e_st = 1; e_off = 0; e_cnt = 0; e_lat = -1;
        for (int f = 0; f < NF; f++) e_len[f] = 0;
        for (int i = 0; i < flen; i++) begin
            b = (i < 64) ? mem[i] : 8'h00;
            if (k < NF && i == pos) begin
                e_len[k] = int'(b);
                pos = pos + int'(b) + 3;
                k++;
            end
            case (ph)
                0: begin
                    if (b == 8'hFF) begin
                        e_off = i + 1; ph = 1;
                        if (i == flen - 1) begin e_st = 3; e_lat = 1; return; end
                    end else if (i == flen - 1) begin
                        e_st = 1; e_lat = 1; return;
                    end
                end
                1: begin
                    if (b[7:4] != 4'h2) begin e_st = 2; e_lat = 1; return; end
                    e_cnt = int'(b[3:0]) << 20; ph = 2;
                    if (i == flen - 1) begin e_st = 3; e_lat = 1; return; end
                end
                2: begin
                    e_cnt = e_cnt | (int'(b) << 12); ph = 3;
                    if (i == flen - 1) begin e_st = 3; e_lat = 1; return; end
                end
                3: begin
                    e_cnt = e_cnt | (int'(b) << 4); ph = 4;
                    if (i == flen - 1) begin e_st = 3; e_lat = 1; return; end
                end
                default: begin
                    e_cnt = e_cnt | int'(b[7:4]);
                    e_st = (e_off + e_cnt / 8 > flen) ? 3 : 0;
                    e_lat = 2;
                    return;
                end
            endcase
        end
    endtask

    task automatic run(input int flen, input string req);
        int i, it, last_it, c_st, c_off, c_cnt;
        bit seen;
        logic [NF*8-1:0] c_len;
        i = 0; it = 0; last_it = -100; seen = 0;
        c_st = 0; c_off = 0; c_cnt = 0; c_len = '0;
        @(negedge clk);
        file_len = flen[IDX_W-1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!seen && it < 600) begin
            if (done) begin
                seen = 1;
                c_st = int'(status); c_off = int'(payload_off);
                c_cnt = int'(bit_count); c_len = field_len;
            end else begin
                if (i < flen && !(gap_mod > 0 && (it % gap_mod) == gap_mod - 1)) begin
                    in_valid = 1'b1;
                    in_data  = (i < 64) ? mem[i] : 8'h00;
                    in_index = i[IDX_W-1:0];
                end else begin
                    in_valid = 1'b0;
                end
                if (in_valid && in_ready) begin
                    i++;
                    last_it = it;
                end
                @(negedge clk);
                it++;
            end
        end
        in_valid = 1'b0;
        model(flen);
        if (!seen) begin
            chk(req, "done never seen", 0, 1);
        end else begin
            chk(req, "status", c_st, e_st);
            if (e_st == 0) begin
                chk("R3", "payload_off", c_off, e_off);
                chk("R6", "bit_count", c_cnt, e_cnt);
            end
            for (int f = 0; f < NF; f++) chk("R9", "field_len", int'(c_len[f*8 +: 8]), e_len[f]);
            if (e_lat > 0) chk("R10", "done latency", it - last_it, e_lat);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int hold_st, hold_cnt, hold_off;
        fill();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "in_ready", in_ready, 0);
        chk("R1", "done", done, 0);
        chk("R1", "status", status, 0);
        chk("R1", "bit_count", bit_count, 0);
        chk("R1", "field_len", field_len, 0);

        // R4 file of length zero and files without sync
        run(0, "R4");
        for (int n = 1; n <= 20; n++) run(n, "R4");

        // R3 R6 R7 sync position sweep, small count that fits
        for (int p = 0; p <= 40; p++) begin
            fill();
            mem[p] = 8'hFF;
            put_count(p + 1, 503, 2);
            run(200, "R3");
        end

        // R11 same sweep with input gaps
        gap_mod = 3;
        for (int p = 0; p <= 12; p++) begin
            fill();
            mem[p] = 8'hFF;
            put_count(p + 1, 12345, 2);
            run(3000, "R11");
        end
        gap_mod = 0;

        // R5 marker nibble sweep
        for (int n = 0; n < 16; n++) begin
            fill();
            mem[20] = 8'hFF;
            put_count(21, 800, n);
            run(200, "R5");
        end

        // R6 R7 wide count patterns against a large file
        for (int k = 0; k < 12; k++) begin
            int cnt;
            cnt = ((k * 32'h13579B) ^ 32'h2468AC) & 32'hFFFFFF;
            fill();
            mem[20] = 8'hFF;
            put_count(21, cnt, 2);
            run(65535, "R6");
        end

        // R7 exact boundary and one below
        for (int k = 1; k <= 10; k++) begin
            int cnt, bnd;
            cnt = k * 4001;
            bnd = 21 + cnt / 8;
            fill();
            mem[20] = 8'hFF;
            put_count(21, cnt, 2);
            run(bnd, "R7");
            run(bnd - 1, "R7");
        end

        // R8 truncation inside the count and sync as last byte
        for (int fl = 10; fl <= 15; fl++) begin
            fill();
            mem[9] = 8'hFF;
            put_count(10, 0, 2);
            run(fl, "R8");
        end

        // R9 field length grid
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 5; b++) begin
                fill();
                mem[15] = 8'(a);
                mem[15 + a + 3] = 8'(b);
                mem[15 + a + 3 + b + 3] = 8'd2;
                mem[45] = 8'hFF;
                put_count(46, 64, 2);
                run(300, "R9");
            end
        end

        // R2 bytes offered while idle are ignored
        hold_st = int'(status); hold_cnt = int'(bit_count); hold_off = int'(payload_off);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'hFF; in_index = IDX_W'(c);
            @(negedge clk);
            chk("R2", "in_ready idle", in_ready, 0);
            chk("R2", "done idle", done, 0);
        end
        in_valid = 1'b0;
        chk("R2", "status held", status, hold_st);
        chk("R2", "bit_count held", bit_count, hold_cnt);
        chk("R2", "payload_off held", payload_off, hold_off);

        // R1 reset in the middle of a parse
        fill();
        @(negedge clk);
        file_len = 16'd30; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3; c++) begin
            in_valid = 1'b1; in_data = 8'h00; in_index = IDX_W'(c);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk("R1", "busy before reset", in_ready, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "in_ready after reset", in_ready, 0);
        chk("R1", "status after reset", status, 0);
        chk("R1", "done after reset", done, 0);
        fill();
        mem[5] = 8'hFF;
        put_count(6, 40, 2);
        run(100, "R1");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule